// File: doc/BRIEF.md
# Two-Master Pipelined Bus Arbiter

This block lets two pipelined bus masters share one slave port. Each master side carries address, write data, read data, strobe, cycle, write enable, acknowledge and stall. The shared side carries the same set, seen from the slave's point of view. A master asks for the bus by raising its cycle line. On a free bus, master 0 wins any tie.

Once a master is granted, it keeps the bus for as long as its cycle line stays high. This holds through idle cycles with no strobe, so a master can lock the slave across a sequence of transfers. The owner's address, write data, strobe, cycle and write enable drive the shared port combinationally. A master raising its cycle line on a free bus is therefore served in that same cycle.

The slave's acknowledge, read data and stall reach the owner only. The other master sees stall held high, acknowledge low and read data zero. The slave should treat a request as valid only when the shared strobe and the shared cycle are both high.

Top module: `dual_master_arbiter`

## Requirements
- R1: After reset, while neither master holds its cycle line high, the shared cycle and strobe are low and both masters see stall high.
- R2: When both masters raise their cycle lines in the same cycle on a free bus, master 0 is granted: the shared address is master 0's address and master 1 sees stall high and acknowledge low.
- R3: While the owner keeps its cycle line high, including cycles with its strobe low, it stays the owner. The other master sees stall high and no acknowledge, and its strobe does not reach the shared port.
- R4: In the first cycle in which the owner's cycle line is low, a requesting other master is granted in that same cycle. The old owner raising its cycle line again on the next cycle does not take the bus back while the new owner holds its cycle line.
- R5: A master that raises its cycle line on a free bus is granted in that cycle. Its address, write data and write enable appear on the shared port with no register delay.
- R6: The owner's stall, acknowledge and read data follow the slave's. A non-owner sees stall 1, acknowledge 0 and read data 0.
- R7: The shared strobe is never high while the shared cycle is low. With no grant, all shared request outputs are zero.
- R8: Data written by one master can be read back by the other after handover, across interleaved single transfers. Each master receives exactly one acknowledge for each accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m0_adr | input | ADDR_W | Master 0 address |
| m0_wdat | input | DATA_W | Master 0 write data |
| m0_rdat | output | DATA_W | Read data to master 0 |
| m0_stb | input | 1 | Master 0 strobe |
| m0_cyc | input | 1 | Master 0 cycle (bus request / lock) |
| m0_we | input | 1 | Master 0 write enable |
| m0_ack | output | 1 | Acknowledge to master 0 |
| m0_stall | output | 1 | Stall to master 0 |
| m1_adr | input | ADDR_W | Master 1 address |
| m1_wdat | input | DATA_W | Master 1 write data |
| m1_rdat | output | DATA_W | Read data to master 1 |
| m1_stb | input | 1 | Master 1 strobe |
| m1_cyc | input | 1 | Master 1 cycle (bus request / lock) |
| m1_we | input | 1 | Master 1 write enable |
| m1_ack | output | 1 | Acknowledge to master 1 |
| m1_stall | output | 1 | Stall to master 1 |
| s_adr | output | ADDR_W | Shared address |
| s_wdat | output | DATA_W | Shared write data |
| s_rdat | input | DATA_W | Read data from slave |
| s_stb | output | 1 | Shared strobe |
| s_cyc | output | 1 | Shared cycle |
| s_we | output | 1 | Shared write enable |
| s_ack | input | 1 | Acknowledge from slave |
| s_stall | input | 1 | Stall from slave |

## Verification
The bench raises both cycle lines in one cycle on a free bus. An arbiter with the tie broken the wrong way would put master 1's address on the shared port. It then holds master 0's cycle line high with its strobe low for several cycles while master 1 keeps strobing. A design that released the bus on an idle strobe would let master 1 through and give it an acknowledge. The bench also drops the owner's cycle line for exactly one cycle and raises it again. A registered-only handover would miss that window, and a design that re-arbitrated every cycle would hand the bus straight back to master 0. Cross-master write/read pairs with a scoreboard catch acknowledges or read data routed to the wrong master.

// File: rtl/bus2_arb_pkg.sv
package bus2_arb_pkg;

    localparam int NUM_MASTERS = 2;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_M0   = 2'd1,
        OWN_M1   = 2'd2
    } owner_t;

    // Decide the owner for this cycle: a holder keeps the bus while its
    // cycle line is high; otherwise master 0 beats master 1.
    function automatic owner_t next_owner(input owner_t held, input logic [1:0] cyc);
        owner_t res;
        res = OWN_NONE;
        if (held == OWN_M0 && cyc[0]) begin
            res = OWN_M0;
        end else if (held == OWN_M1 && cyc[1]) begin
            res = OWN_M1;
        end else if (cyc[0]) begin
            res = OWN_M0;
        end else if (cyc[1]) begin
            res = OWN_M1;
        end
        return res;
    endfunction

    function automatic logic [1:0] owner_onehot(input owner_t o);
        logic [1:0] v;
        case (o)
            OWN_M0:  v = 2'b01;
            OWN_M1:  v = 2'b10;
            default: v = 2'b00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/arb_owner_ctrl.sv
module arb_owner_ctrl
    import bus2_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cyc,
    output logic [1:0] gnt
);
    owner_t owner_q;
    owner_t owner_now;

    always_comb begin
        owner_now = next_owner(owner_q, cyc);
        gnt       = owner_onehot(owner_now);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q <= OWN_NONE;
        end else begin
            owner_q <= owner_now;
        end
    end
endmodule

// File: rtl/arb_req_mux.sv
module arb_req_mux #(
    parameter int AW = 20,
    parameter int DW = 16,
    parameter int NM = 2
) (
    input  logic [NM-1:0]         gnt,
    input  logic [NM-1:0][AW-1:0] m_adr,
    input  logic [NM-1:0][DW-1:0] m_wdat,
    input  logic [NM-1:0]         m_stb,
    input  logic [NM-1:0]         m_cyc,
    input  logic [NM-1:0]         m_we,
    output logic [AW-1:0]         s_adr,
    output logic [DW-1:0]         s_wdat,
    output logic                  s_stb,
    output logic                  s_cyc,
    output logic                  s_we
);
    always_comb begin
        s_adr  = '0;
        s_wdat = '0;
        s_stb  = 1'b0;
        s_cyc  = 1'b0;
        s_we   = 1'b0;
        for (int i = 0; i < NM; i++) begin
            if (gnt[i]) begin
                s_adr  = m_adr[i];
                s_wdat = m_wdat[i];
                s_stb  = m_stb[i] & m_cyc[i];
                s_cyc  = m_cyc[i];
                s_we   = m_we[i];
            end
        end
    end
endmodule

// File: rtl/arb_resp_route.sv
module arb_resp_route #(
    parameter int DW = 16,
    parameter int NM = 2
) (
    input  logic [NM-1:0]         gnt,
    input  logic                  s_ack,
    input  logic [DW-1:0]         s_rdat,
    input  logic                  s_stall,
    output logic [NM-1:0]         m_ack,
    output logic [NM-1:0][DW-1:0] m_rdat,
    output logic [NM-1:0]         m_stall
);
    for (genvar g = 0; g < NM; g++) begin : g_port
        assign m_ack[g]   = gnt[g] & s_ack;
        assign m_stall[g] = ~gnt[g] | s_stall;
        assign m_rdat[g]  = gnt[g] ? s_rdat : '0;
    end
endmodule

// File: rtl/dual_master_arbiter.sv
module dual_master_arbiter
    import bus2_arb_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] m0_adr,
    input  logic [DATA_W-1:0] m0_wdat,
    output logic [DATA_W-1:0] m0_rdat,
    input  logic              m0_stb,
    input  logic              m0_cyc,
    input  logic              m0_we,
    output logic              m0_ack,
    output logic              m0_stall,
    input  logic [ADDR_W-1:0] m1_adr,
    input  logic [DATA_W-1:0] m1_wdat,
    output logic [DATA_W-1:0] m1_rdat,
    input  logic              m1_stb,
    input  logic              m1_cyc,
    input  logic              m1_we,
    output logic              m1_ack,
    output logic              m1_stall,
    output logic [ADDR_W-1:0] s_adr,
    output logic [DATA_W-1:0] s_wdat,
    input  logic [DATA_W-1:0] s_rdat,
    output logic              s_stb,
    output logic              s_cyc,
    output logic              s_we,
    input  logic              s_ack,
    input  logic              s_stall
);
    localparam int NM = NUM_MASTERS;

    logic [NM-1:0]             gnt;
    logic [NM-1:0][ADDR_W-1:0] adr_v;
    logic [NM-1:0][DATA_W-1:0] wdat_v;
    logic [NM-1:0][DATA_W-1:0] rdat_v;
    logic [NM-1:0]             stb_v, cyc_v, we_v, ack_v, stall_v;

    assign adr_v  = {m1_adr, m0_adr};
    assign wdat_v = {m1_wdat, m0_wdat};
    assign stb_v  = {m1_stb, m0_stb};
    assign cyc_v  = {m1_cyc, m0_cyc};
    assign we_v   = {m1_we, m0_we};

    arb_owner_ctrl u_owner (
        .clk (clk),
        .rst (rst),
        .cyc (cyc_v),
        .gnt (gnt)
    );

    arb_req_mux #(.AW(ADDR_W), .DW(DATA_W), .NM(NM)) u_req (
        .gnt    (gnt),
        .m_adr  (adr_v),
        .m_wdat (wdat_v),
        .m_stb  (stb_v),
        .m_cyc  (cyc_v),
        .m_we   (we_v),
        .s_adr  (s_adr),
        .s_wdat (s_wdat),
        .s_stb  (s_stb),
        .s_cyc  (s_cyc),
        .s_we   (s_we)
    );

    arb_resp_route #(.DW(DATA_W), .NM(NM)) u_resp (
        .gnt     (gnt),
        .s_ack   (s_ack),
        .s_rdat  (s_rdat),
        .s_stall (s_stall),
        .m_ack   (ack_v),
        .m_rdat  (rdat_v),
        .m_stall (stall_v)
    );

    assign m0_ack   = ack_v[0];
    assign m1_ack   = ack_v[1];
    assign m0_stall = stall_v[0];
    assign m1_stall = stall_v[1];
    assign m0_rdat  = rdat_v[0];
    assign m1_rdat  = rdat_v[1];
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst,
    input logic          m0_cyc,
    input logic          m1_cyc,
    input logic          m0_stall,
    input logic          m1_stall,
    input logic          m0_ack,
    input logic          m1_ack,
    input logic          s_cyc,
    input logic          s_stb,
    input logic [AW-1:0] s_adr,
    input logic [AW-1:0] m0_adr,
    input logic [AW-1:0] m1_adr
);
    // R1
    idle_outputs_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!m0_cyc && !m1_cyc) |-> (!s_cyc && !s_stb && m0_stall && m1_stall));

    // R2
    m0_priority_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!m0_cyc && !m1_cyc) && m0_cyc && m1_cyc) |-> (m1_stall && !m1_ack && s_adr == m0_adr));

    // R3
    m1_lock_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(s_cyc && m1_cyc && !m0_cyc) && m1_cyc) |-> (m0_stall && !m0_ack));

    // R3
    m0_lock_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(s_cyc && m0_cyc && !m1_cyc) && m0_cyc) |-> (m1_stall && !m1_ack));

    // R4
    handover_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(m0_cyc) && !m0_cyc && m1_cyc) |-> (s_cyc && s_adr == m1_adr));

    // R6
    single_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !(m0_ack && m1_ack));

    // R6
    single_unstalled_chk: assert property (@(posedge clk) disable iff (rst)
        (m0_stall || m1_stall));

    // R7
    stb_needs_cyc_chk: assert property (@(posedge clk) disable iff (rst)
        s_stb |-> s_cyc);
endmodule

bind dual_master_arbiter arb_checker #(.AW(ADDR_W)) u_arb_chk (
    .clk      (clk),
    .rst      (rst),
    .m0_cyc   (m0_cyc),
    .m1_cyc   (m1_cyc),
    .m0_stall (m0_stall),
    .m1_stall (m1_stall),
    .m0_ack   (m0_ack),
    .m1_ack   (m1_ack),
    .s_cyc    (s_cyc),
    .s_stb    (s_stb),
    .s_adr    (s_adr),
    .m0_adr   (m0_adr),
    .m1_adr   (m1_adr)
);

// File: tb/dual_master_arbiter_test.sv
`timescale 1ns/1ps
module dual_master_arbiter_test;
    localparam int AW = 20;
    localparam int DW = 16;

    typedef struct packed {
        logic          rd;
        logic [DW-1:0] d;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [AW-1:0] adr [2];
    logic [DW-1:0] wd  [2];
    logic          stb [2];
    logic          cyc [2];
    logic          we  [2];

    logic [DW-1:0] m0_rdat, m1_rdat, s_wdat, s_rdat;
    logic [AW-1:0] s_adr;
    logic m0_ack, m1_ack, m0_stall, m1_stall, s_stb, s_cyc, s_we;
    logic s_ack = 1'b0;
    logic slv_stall = 1'b0;
    logic [DW-1:0] slv_mem [256];
    logic [DW-1:0] ref_mem [256];

    exp_t q0[$];
    exp_t q1[$];
    int compared = 0;
    int mismatched = 0;
    logic done = 1'b0;

    dual_master_arbiter #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst),
        .m0_adr(adr[0]), .m0_wdat(wd[0]), .m0_rdat(m0_rdat), .m0_stb(stb[0]),
        .m0_cyc(cyc[0]), .m0_we(we[0]), .m0_ack(m0_ack), .m0_stall(m0_stall),
        .m1_adr(adr[1]), .m1_wdat(wd[1]), .m1_rdat(m1_rdat), .m1_stb(stb[1]),
        .m1_cyc(cyc[1]), .m1_we(we[1]), .m1_ack(m1_ack), .m1_stall(m1_stall),
        .s_adr(s_adr), .s_wdat(s_wdat), .s_rdat(s_rdat), .s_stb(s_stb),
        .s_cyc(s_cyc), .s_we(s_we), .s_ack(s_ack), .s_stall(slv_stall)
    );

    // Pipelined memory slave: one-cycle acknowledge after an accepted request
    always @(posedge clk) begin
        if (rst) begin
            s_ack <= 1'b0;
        end else if (s_cyc && s_stb && !slv_stall) begin
            s_ack <= 1'b1;
            if (s_we) slv_mem[s_adr[7:0]] <= s_wdat;
            else      s_rdat <= slv_mem[s_adr[7:0]];
        end else begin
            s_ack <= 1'b0;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic stall_of(input int m);
        return (m == 0) ? m0_stall : m1_stall;
    endfunction

    function automatic logic ack_of(input int m);
        return (m == 0) ? m0_ack : m1_ack;
    endfunction

    task automatic push_exp(input int m, input logic rd, input logic [AW-1:0] a, input logic [DW-1:0] d);
        exp_t e;
        e.rd = rd;
        if (rd) e.d = ref_mem[a[7:0]];
        else begin
            e.d = d;
            ref_mem[a[7:0]] = d;
        end
        if (m == 0) q0.push_back(e);
        else        q1.push_back(e);
    endtask

    // Single transfer by master m; cycle kept high afterwards when hold is set
    task automatic xfer(input int m, input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic hold);
        @(negedge clk);
        cyc[m] = 1'b1; stb[m] = 1'b1; we[m] = wr; adr[m] = a; wd[m] = d;
        #1;
        while (stall_of(m)) begin
            @(negedge clk);
            #1;
        end
        push_exp(m, !wr, a, d);
        @(negedge clk);
        stb[m] = 1'b0;
        #1;
        while (!ack_of(m)) begin
            @(negedge clk);
            #1;
        end
        if (!hold) cyc[m] = 1'b0;
    endtask

    // Scoreboard monitor (R8, R6)
    task automatic pop_cmp(input int m, input logic [DW-1:0] rdat);
        exp_t e;
        if ((m == 0 && q0.size() == 0) || (m == 1 && q1.size() == 0)) begin
            chk("R8", "unexpected ack", 32'(m), 32'hffff_ffff);
            return;
        end
        e = (m == 0) ? q0.pop_front() : q1.pop_front();
        if (e.rd) chk("R8", "read data", 32'(rdat), 32'(e.d));
    endtask

    always begin
        @(posedge clk);
        #1;
        if (!rst) begin
            if (m0_ack) pop_cmp(0, m0_rdat);
            if (m1_ack) pop_cmp(1, m1_rdat);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            slv_mem[i] = '0;
            ref_mem[i] = '0;
        end
        for (int m = 0; m < 2; m++) begin
            adr[m] = '0; wd[m] = '0; stb[m] = 1'b0; cyc[m] = 1'b0; we[m] = 1'b0;
        end
        s_rdat = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        #1;
        chk("R1", "s_cyc", 32'(s_cyc), 0);
        chk("R1", "s_stb", 32'(s_stb), 0);
        chk("R1", "m0_stall", 32'(m0_stall), 1);
        chk("R1", "m1_stall", 32'(m1_stall), 1);

        // R5: same-cycle grant on a free bus
        @(negedge clk);
        cyc[1] = 1'b1; stb[1] = 1'b1; we[1] = 1'b1; adr[1] = 20'h30000; wd[1] = 16'h03e8;
        #1;
        chk("R5", "s_cyc", 32'(s_cyc), 1);
        chk("R5", "s_adr", 32'(s_adr), 32'h30000);
        chk("R5", "s_wdat", 32'(s_wdat), 32'h03e8);
        chk("R5", "s_we", 32'(s_we), 1);
        chk("R5", "m1_stall", 32'(m1_stall), 0);
        push_exp(1, 1'b0, 20'h30000, 16'h03e8);
        @(negedge clk);
        stb[1] = 1'b0;
        #1;
        while (!m1_ack) begin @(negedge clk); #1; end
        cyc[1] = 1'b0;
        @(negedge clk);

        // R2: simultaneous request, master 0 wins
        @(negedge clk);
        cyc[0] = 1'b1; stb[0] = 1'b1; we[0] = 1'b1; adr[0] = 20'h00010; wd[0] = 16'habcd;
        cyc[1] = 1'b1; stb[1] = 1'b1; we[1] = 1'b1; adr[1] = 20'h30020; wd[1] = 16'h1111;
        #1;
        chk("R2", "s_adr", 32'(s_adr), 32'h00010);
        chk("R2", "m0_stall", 32'(m0_stall), 0);
        chk("R2", "m1_stall", 32'(m1_stall), 1);
        push_exp(0, 1'b0, 20'h00010, 16'habcd);
        @(negedge clk);
        stb[0] = 1'b0;
        #1;
        while (!m0_ack) begin @(negedge clk); #1; end

        // R3: owner holds cycle with strobe low, other master locked out
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            #1;
            chk("R3", "m1_stall", 32'(m1_stall), 1);
            chk("R3", "m1_ack", 32'(m1_ack), 0);
            chk("R3", "s_stb", 32'(s_stb), 0);
        end
        xfer(0, 1'b1, 20'h00011, 16'h1234, 1'b1);
        #1;
        chk("R3", "m1_stall after locked write", 32'(m1_stall), 1);

        // R4: owner drops cycle, other granted in the same cycle
        @(negedge clk);
        cyc[0] = 1'b0;
        #1;
        chk("R4", "s_adr", 32'(s_adr), 32'h30020);
        chk("R4", "m1_stall", 32'(m1_stall), 0);
        push_exp(1, 1'b0, 20'h30020, 16'h1111);
        @(negedge clk);
        stb[1] = 1'b0;
        cyc[0] = 1'b1; stb[0] = 1'b1; we[0] = 1'b1; adr[0] = 20'h00012; wd[0] = 16'h5555;
        #1;
        chk("R4", "m0_stall on re-raise", 32'(m0_stall), 1);
        chk("R4", "s_adr stays m1", 32'(s_adr), 32'h30020);
        @(negedge clk);
        cyc[1] = 1'b0;
        #1;
        chk("R4", "s_adr back to m0", 32'(s_adr), 32'h00012);
        chk("R4", "m0_stall", 32'(m0_stall), 0);
        push_exp(0, 1'b0, 20'h00012, 16'h5555);
        @(negedge clk);
        stb[0] = 1'b0;
        #1;
        while (!m0_ack) begin @(negedge clk); #1; end
        cyc[0] = 1'b0;

        // R6: slave stall reaches the owner only; non-owner read data is zero
        @(negedge clk);
        slv_stall = 1'b1;
        cyc[0] = 1'b1; stb[0] = 1'b1; we[0] = 1'b0; adr[0] = 20'h00010;
        #1;
        chk("R6", "owner stall follows slave", 32'(m0_stall), 1);
        chk("R6", "non-owner stall", 32'(m1_stall), 1);
        @(negedge clk);
        slv_stall = 1'b0;
        #1;
        chk("R6", "owner stall released", 32'(m0_stall), 0);
        push_exp(0, 1'b1, 20'h00010, '0);
        @(negedge clk);
        stb[0] = 1'b0;
        #1;
        while (!m0_ack) begin @(negedge clk); #1; end
        chk("R6", "owner read data", 32'(m0_rdat), 32'habcd);
        chk("R6", "non-owner read data", 32'(m1_rdat), 0);
        chk("R6", "non-owner ack", 32'(m1_ack), 0);
        cyc[0] = 1'b0;

        // R8: cross-master reads after handover, interleaved single transfers
        xfer(1, 1'b0, 20'h00011, '0, 1'b0);
        xfer(0, 1'b0, 20'h30020, '0, 1'b0);
        for (int i = 0; i < 6; i++) begin
            xfer(i % 2, 1'b1, 20'(32'h40 + i), 16'(16'h8a00 + i * 16'h0111), 1'b0);
            xfer((i + 1) % 2, 1'b0, 20'(32'h40 + i), '0, 1'b0);
        end

        // R7: no grant, shared outputs zero
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R7", "s_cyc idle", 32'(s_cyc), 0);
        chk("R7", "s_stb idle", 32'(s_stb), 0);
        chk("R7", "s_adr idle", 32'(s_adr), 0);
        chk("R8", "m0 queue drained", 32'(q0.size()), 0);
        chk("R8", "m1 queue drained", 32'(q1.size()), 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule